// File: doc/BRIEF.md
# Folding Branch Target Buffer

This block is a direct-mapped branch target buffer that keeps two kinds of entry. A conditional entry holds a predicted target address and one taken bit. An unconditional entry holds the instruction word found at the branch target, together with the address that follows that word. When fetch looks up a PC that hits an unconditional entry, the stored word goes to decode in place of the branch. Fetch then continues from the stored follow-on address. The branch leaves the pipeline, which saves one cycle (a penalty of minus one).

Execute resolves each branch through the update port. At that point the block reads the entry at the resolved PC again and works out what fetch was told. It then compares this with the real outcome. On a mismatch it raises a one-cycle redirect that carries the correct PC. It also allocates or rewrites the entry. Four saturating event counters (hits, misses, folds and redirects) let the total cycle penalty be worked out as two cycles for each redirect minus one cycle for each fold. A correct conditional prediction costs nothing. A wrong prediction or a miss on a taken branch costs two cycles.

Top module: `fold_btb`

## Requirements
- R1: After reset every entry is invalid. Every lookup misses with `lk_next_pc` = `lk_pc` + 4, every counter reads 0 and `redirect` is low.
- R2: A resolved conditional taken branch that misses raises `redirect` in the cycle after the update, with `redirect_pc` = target. The entry is allocated, so a later lookup hits with `lk_uncond`=0, `lk_taken`=1, `lk_target` = `lk_next_pc` = target.
- R3: A resolved conditional not-taken branch that misses gives no redirect and allocates nothing: a later lookup of that PC still misses.
- R4: A resolved unconditional branch that misses redirects to its target and allocates an unconditional entry. A later lookup gives `lk_hit`=1, `lk_uncond`=1, `lk_fold`=1, `lk_insn` = the stored word, `lk_target` = target and `lk_next_pc` = target + 4.
- R5: An unconditional branch resolved against a matching unconditional entry with the same target gives no redirect and adds one to the fold counter.
- R6: A conditional hit whose stored direction is wrong redirects to the real next PC (target, or PC + 4 when not taken). The stored direction is then rewritten.
- R7: The index is PC bits [IDX_W+1:2] and the tag is the bits above them. PC bits [1:0] are ignored. A PC with the same index but a different tag misses, and allocating it replaces the earlier entry.
- R8: Each update adds one to the hit counter (on a tag match) or to the miss counter (otherwise). It also adds one to the redirect counter on a mismatch and to the fold counter on a fold. Every counter stops at its all-ones value, and no counter moves without an update.
- R9: `redirect` is a single-cycle pulse. It is high only in the cycle after an update whose predicted next PC differed from the real one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_hit | output | 1 | Valid entry with matching tag |
| lk_uncond | output | 1 | Hit entry is unconditional |
| lk_taken | output | 1 | Predicted taken |
| lk_fold | output | 1 | Supply `lk_insn` to decode in place of the branch |
| lk_target | output | PC_W | Predicted branch target on a hit |
| lk_insn | output | INSN_W | Folded target instruction |
| lk_next_pc | output | PC_W | Next fetch PC |
| up_valid | input | 1 | A branch resolves this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_uncond | input | 1 | Resolved branch is unconditional |
| up_taken | input | 1 | Real direction (conditional only) |
| up_target | input | PC_W | Real branch target |
| up_insn | input | INSN_W | Instruction word at the target |
| redirect | output | 1 | Fetch must restart |
| redirect_pc | output | PC_W | Correct PC when `redirect` is high |
| cnt_hit | output | CNT_W | Saturating hit count |
| cnt_miss | output | CNT_W | Saturating miss count |
| cnt_fold | output | CNT_W | Saturating fold count |
| cnt_redirect | output | CNT_W | Saturating redirect count |

## Verification
A corrupt tag, kind, direction or address in an entry shows up at the next lookup of that index, in the same cycle, as a wrong `lk_hit`, `lk_fold` or `lk_next_pc`. When that branch resolves, the same fault appears one clock later as an unexpected or missing `redirect` pulse and as a counter that moves the wrong way. A bad write-enable leaves a stale entry behind. That stale entry is only seen the next time a PC with the same index is looked up. For this reason the sweep reuses every index with several tags.

// File: rtl/fold_btb_pkg.sv
package fold_btb_pkg;
    typedef enum logic {
        KIND_COND   = 1'b0,
        KIND_UNCOND = 1'b1
    } br_kind_e;

    localparam int EV_HIT      = 0;
    localparam int EV_MISS     = 1;
    localparam int EV_FOLD     = 2;
    localparam int EV_REDIRECT = 3;
    localparam int EV_NUM      = 4;
endpackage

// File: rtl/fold_btb_store.sv
module fold_btb_store
    import fold_btb_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 3,
    parameter int INSN_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [IDX_W-1:0]      ra_idx,
    output logic                  ra_valid,
    output logic [PC_W-IDX_W-3:0] ra_tag,
    output br_kind_e              ra_kind,
    output logic                  ra_taken,
    output logic [PC_W-1:0]       ra_addr,
    output logic [INSN_W-1:0]     ra_insn,
    input  logic [IDX_W-1:0]      rb_idx,
    output logic                  rb_valid,
    output logic [PC_W-IDX_W-3:0] rb_tag,
    output br_kind_e              rb_kind,
    output logic                  rb_taken,
    output logic [PC_W-1:0]       rb_addr,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [PC_W-IDX_W-3:0] wr_tag,
    input  br_kind_e              wr_kind,
    input  logic                  wr_taken,
    input  logic [PC_W-1:0]       wr_addr,
    input  logic [INSN_W-1:0]     wr_insn
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = PC_W - IDX_W - 2;

    logic              valid_a [DEPTH];
    logic [TAG_W-1:0]  tag_a   [DEPTH];
    br_kind_e          kind_a  [DEPTH];
    logic              taken_a [DEPTH];
    logic [PC_W-1:0]   addr_a  [DEPTH];
    logic [INSN_W-1:0] insn_a  [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        br_kind_e          k_q;
        logic              tk_q;
        logic [PC_W-1:0]   a_q;
        logic [INSN_W-1:0] i_q;
        logic              sel;

        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q  <= 1'b0;
                t_q  <= '0;
                k_q  <= KIND_COND;
                tk_q <= 1'b0;
                a_q  <= '0;
                i_q  <= '0;
            end else if (sel) begin
                v_q  <= 1'b1;
                t_q  <= wr_tag;
                k_q  <= wr_kind;
                tk_q <= wr_taken;
                a_q  <= wr_addr;
                i_q  <= wr_insn;
            end
        end

        assign valid_a[e] = v_q;
        assign tag_a[e]   = t_q;
        assign kind_a[e]  = k_q;
        assign taken_a[e] = tk_q;
        assign addr_a[e]  = a_q;
        assign insn_a[e]  = i_q;
    end

    assign ra_valid = valid_a[ra_idx];
    assign ra_tag   = tag_a[ra_idx];
    assign ra_kind  = kind_a[ra_idx];
    assign ra_taken = taken_a[ra_idx];
    assign ra_addr  = addr_a[ra_idx];
    assign ra_insn  = insn_a[ra_idx];

    assign rb_valid = valid_a[rb_idx];
    assign rb_tag   = tag_a[rb_idx];
    assign rb_kind  = kind_a[rb_idx];
    assign rb_taken = taken_a[rb_idx];
    assign rb_addr  = addr_a[rb_idx];
endmodule

// File: rtl/fold_btb_resolve.sv
module fold_btb_resolve
    import fold_btb_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 3,
    parameter int INSN_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  up_valid,
    input  logic [PC_W-1:0]       up_pc,
    input  br_kind_e              up_kind,
    input  logic                  up_taken,
    input  logic [PC_W-1:0]       up_target,
    input  logic [INSN_W-1:0]     up_insn,
    output logic [IDX_W-1:0]      e_idx,
    input  logic                  e_valid,
    input  logic [PC_W-IDX_W-3:0] e_tag,
    input  br_kind_e              e_kind,
    input  logic                  e_taken,
    input  logic [PC_W-1:0]       e_addr,
    output logic                  wr_en,
    output logic [PC_W-IDX_W-3:0] wr_tag,
    output br_kind_e              wr_kind,
    output logic                  wr_taken,
    output logic [PC_W-1:0]       wr_addr,
    output logic [INSN_W-1:0]     wr_insn,
    output logic [EV_NUM-1:0]     ev,
    output logic                  redirect,
    output logic [PC_W-1:0]       redirect_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic            hit;
    logic            mismatch;
    logic            fold;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] pred_pc;
    logic [PC_W-1:0] real_pc;

    assign e_idx  = up_pc[IDX_W+1:2];
    assign wr_tag = up_pc[PC_W-1:IDX_W+2];

    always_comb begin
        seq_pc = up_pc + STEP;
        hit    = e_valid && (e_tag == wr_tag);
        if (!hit)                     pred_pc = seq_pc;
        else if (e_kind == KIND_UNCOND) pred_pc = e_addr - STEP;
        else if (e_taken)              pred_pc = e_addr;
        else                           pred_pc = seq_pc;
        if (up_kind == KIND_UNCOND || up_taken) real_pc = up_target;
        else                                    real_pc = seq_pc;
        mismatch = pred_pc != real_pc;
        fold     = hit && e_kind == KIND_UNCOND && up_kind == KIND_UNCOND && !mismatch;

        ev              = '0;
        ev[EV_HIT]      = up_valid && hit;
        ev[EV_MISS]     = up_valid && !hit;
        ev[EV_FOLD]     = up_valid && fold;
        ev[EV_REDIRECT] = up_valid && mismatch;

        wr_en    = up_valid && (up_kind == KIND_UNCOND || hit || up_taken);
        wr_kind  = up_kind;
        wr_taken = (up_kind == KIND_UNCOND) ? 1'b1 : up_taken;
        wr_addr  = (up_kind == KIND_UNCOND) ? up_target + STEP : up_target;
        wr_insn  = (up_kind == KIND_UNCOND) ? up_insn : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redirect    <= 1'b0;
            redirect_pc <= '0;
        end else begin
            redirect <= up_valid && mismatch;
            if (up_valid && mismatch) redirect_pc <= real_pc;
        end
    end
endmodule

// File: rtl/fold_btb_counters.sv
module fold_btb_counters #(
    parameter int N     = 4,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N-1:0]           ev,
    output logic [N-1:0][CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = '1;

    for (genvar c = 0; c < N; c++) begin : g_cnt
        logic [CNT_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 q <= '0;
            else if (ev[c] && q != TOP) q <= q + CNT_W'(1);
        end
        assign cnt[c] = q;
    end
endmodule

// File: rtl/fold_btb.sv
module fold_btb
    import fold_btb_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 3,
    parameter int INSN_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_hit,
    output logic              lk_uncond,
    output logic              lk_taken,
    output logic              lk_fold,
    output logic [PC_W-1:0]   lk_target,
    output logic [INSN_W-1:0] lk_insn,
    output logic [PC_W-1:0]   lk_next_pc,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic              up_uncond,
    input  logic              up_taken,
    input  logic [PC_W-1:0]   up_target,
    input  logic [INSN_W-1:0] up_insn,
    output logic              redirect,
    output logic [PC_W-1:0]   redirect_pc,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_miss,
    output logic [CNT_W-1:0]  cnt_fold,
    output logic [CNT_W-1:0]  cnt_redirect
);
    localparam int TAG_W = PC_W - IDX_W - 2;
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    logic              ra_valid;
    logic [TAG_W-1:0]  ra_tag;
    br_kind_e          ra_kind;
    logic              ra_taken;
    logic [PC_W-1:0]   ra_addr;
    logic [INSN_W-1:0] ra_insn;
    logic [IDX_W-1:0]  rb_idx;
    logic              rb_valid;
    logic [TAG_W-1:0]  rb_tag;
    br_kind_e          rb_kind;
    logic              rb_taken;
    logic [PC_W-1:0]   rb_addr;
    logic              wr_en;
    logic [TAG_W-1:0]  wr_tag;
    br_kind_e          wr_kind;
    logic              wr_taken;
    logic [PC_W-1:0]   wr_addr;
    logic [INSN_W-1:0] wr_insn;
    logic [EV_NUM-1:0] ev;
    logic [EV_NUM-1:0][CNT_W-1:0] cnt;
    br_kind_e          up_kind;

    assign up_kind = up_uncond ? KIND_UNCOND : KIND_COND;

    fold_btb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .INSN_W(INSN_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(lk_pc[IDX_W+1:2]), .ra_valid(ra_valid), .ra_tag(ra_tag),
        .ra_kind(ra_kind), .ra_taken(ra_taken), .ra_addr(ra_addr), .ra_insn(ra_insn),
        .rb_idx(rb_idx), .rb_valid(rb_valid), .rb_tag(rb_tag),
        .rb_kind(rb_kind), .rb_taken(rb_taken), .rb_addr(rb_addr),
        .wr_en(wr_en), .wr_idx(rb_idx), .wr_tag(wr_tag), .wr_kind(wr_kind),
        .wr_taken(wr_taken), .wr_addr(wr_addr), .wr_insn(wr_insn)
    );

    fold_btb_resolve #(.PC_W(PC_W), .IDX_W(IDX_W), .INSN_W(INSN_W)) u_resolve (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_pc(up_pc), .up_kind(up_kind), .up_taken(up_taken),
        .up_target(up_target), .up_insn(up_insn),
        .e_idx(rb_idx), .e_valid(rb_valid), .e_tag(rb_tag), .e_kind(rb_kind),
        .e_taken(rb_taken), .e_addr(rb_addr),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_kind(wr_kind), .wr_taken(wr_taken),
        .wr_addr(wr_addr), .wr_insn(wr_insn), .ev(ev),
        .redirect(redirect), .redirect_pc(redirect_pc)
    );

    fold_btb_counters #(.N(EV_NUM), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ev(ev), .cnt(cnt)
    );

    assign cnt_hit      = cnt[EV_HIT];
    assign cnt_miss     = cnt[EV_MISS];
    assign cnt_fold     = cnt[EV_FOLD];
    assign cnt_redirect = cnt[EV_REDIRECT];

    always_comb begin
        lk_hit    = ra_valid && (ra_tag == lk_pc[PC_W-1:IDX_W+2]);
        lk_uncond = lk_hit && ra_kind == KIND_UNCOND;
        lk_fold   = lk_uncond;
        lk_taken  = lk_hit && (ra_kind == KIND_UNCOND || ra_taken);
        lk_insn   = lk_uncond ? ra_insn : '0;
        if (!lk_hit)         lk_target = '0;
        else if (lk_uncond)  lk_target = ra_addr - STEP;
        else                 lk_target = ra_addr;
        if (lk_taken)        lk_next_pc = ra_addr;
        else                 lk_next_pc = lk_pc + STEP;
    end
endmodule

// File: rtl/fold_btb_chk.sv
module fold_btb_chk #(
    parameter int PC_W  = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  lk_pc,
    input logic             lk_hit,
    input logic             lk_uncond,
    input logic             lk_fold,
    input logic [PC_W-1:0]  lk_target,
    input logic [PC_W-1:0]  lk_next_pc,
    input logic             up_valid,
    input logic             redirect,
    input logic [CNT_W-1:0] cnt_hit,
    input logic [CNT_W-1:0] cnt_miss,
    input logic [CNT_W-1:0] cnt_fold,
    input logic [CNT_W-1:0] cnt_redirect
);
    assert_miss_falls_through_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_next_pc == lk_pc + PC_W'(4));

    assert_redirect_after_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> $past(up_valid));

    assert_fold_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fold |-> (lk_hit && lk_uncond && lk_next_pc == lk_target + PC_W'(4)));

    assert_fold_no_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_fold != $past(cnt_fold)) |-> !redirect);

    assert_counters_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> ($stable(cnt_hit) && $stable(cnt_miss) &&
                       $stable(cnt_fold) && $stable(cnt_redirect)));
endmodule

bind fold_btb fold_btb_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_uncond(lk_uncond),
    .lk_fold(lk_fold), .lk_target(lk_target), .lk_next_pc(lk_next_pc),
    .up_valid(up_valid), .redirect(redirect), .cnt_hit(cnt_hit), .cnt_miss(cnt_miss),
    .cnt_fold(cnt_fold), .cnt_redirect(cnt_redirect)
);

// File: tb/fold_btb_test.sv
`timescale 1ns/1ps
module fold_btb_test;
    localparam int CMAX = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit, lk_uncond, lk_taken, lk_fold;
    logic [31:0] lk_target, lk_insn, lk_next_pc;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_uncond = 1'b0;
    logic        up_taken = 1'b0;
    logic [31:0] up_target = '0;
    logic [31:0] up_insn = '0;
    logic        redirect;
    logic [31:0] redirect_pc;
    logic [3:0]  cnt_hit, cnt_miss, cnt_fold, cnt_redirect;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic        m_v   [4];
    logic [27:0] m_tag [4];
    logic        m_unc [4];
    logic        m_tk  [4];
    logic [31:0] m_addr[4];
    logic [31:0] m_insn[4];
    int e_hit = 0, e_miss = 0, e_fold = 0, e_red = 0;

    always #2 clk = ~clk;

    fold_btb #(.PC_W(32), .IDX_W(2), .INSN_W(32), .CNT_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_uncond(lk_uncond),
        .lk_taken(lk_taken), .lk_fold(lk_fold), .lk_target(lk_target), .lk_insn(lk_insn),
        .lk_next_pc(lk_next_pc), .up_valid(up_valid), .up_pc(up_pc), .up_uncond(up_uncond),
        .up_taken(up_taken), .up_target(up_target), .up_insn(up_insn),
        .redirect(redirect), .redirect_pc(redirect_pc), .cnt_hit(cnt_hit),
        .cnt_miss(cnt_miss), .cnt_fold(cnt_fold), .cnt_redirect(cnt_redirect)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v >= CMAX) ? CMAX : v + 1;
    endfunction

    task automatic look(input logic [31:0] pc, input string rq);
        int          ix = int'(pc[3:2]);
        logic        mh;
        logic [31:0] en;
        @(negedge clk);
        lk_pc = pc;
        #1;
        mh = m_v[ix] && m_tag[ix] == pc[31:4];
        if (!mh) en = pc + 4;
        else if (m_unc[ix] || m_tk[ix]) en = m_addr[ix];
        else en = pc + 4;
        chk(rq, "lk_hit", {31'b0, lk_hit}, {31'b0, mh});
        chk(rq, "lk_next_pc", lk_next_pc, en);
        chk(rq, "lk_fold", {31'b0, lk_fold}, {31'b0, mh && m_unc[ix]});
        if (mh && m_unc[ix]) begin
            chk(rq, "lk_insn", lk_insn, m_insn[ix]);
            chk(rq, "lk_target", lk_target, m_addr[ix] - 4);
        end else if (mh) begin
            chk(rq, "lk_target", lk_target, m_addr[ix]);
            chk(rq, "lk_taken", {31'b0, lk_taken}, {31'b0, m_tk[ix]});
        end
    endtask

    task automatic step(input logic [31:0] pc, input bit unc, input bit tk,
                        input logic [31:0] tgt, input logic [31:0] ins, input string rq);
        int          ix = int'(pc[3:2]);
        logic        mh;
        logic [31:0] pt, an;
        bit          rd, fd;
        look(pc, rq);
        mh = m_v[ix] && m_tag[ix] == pc[31:4];
        if (!mh) pt = pc + 4;
        else if (m_unc[ix]) pt = m_addr[ix] - 4;
        else pt = m_tk[ix] ? m_addr[ix] : pc + 4;
        an = (unc || tk) ? tgt : pc + 4;
        rd = pt != an;
        fd = mh && m_unc[ix] && unc && !rd;
        up_pc = pc; up_uncond = unc; up_taken = tk; up_target = tgt; up_insn = ins;
        up_valid = 1'b1;
        @(posedge clk);
        #1;
        up_valid = 1'b0;
        chk(rq, "redirect", {31'b0, redirect}, {31'b0, rd});
        if (rd) chk(rq, "redirect_pc", redirect_pc, an);
        if (mh) e_hit = sat(e_hit); else e_miss = sat(e_miss);
        if (fd) e_fold = sat(e_fold);
        if (rd) e_red = sat(e_red);
        chk(rq, "cnt_hit", {28'b0, cnt_hit}, e_hit);
        chk(rq, "cnt_miss", {28'b0, cnt_miss}, e_miss);
        chk(rq, "cnt_fold", {28'b0, cnt_fold}, e_fold);
        chk(rq, "cnt_redirect", {28'b0, cnt_redirect}, e_red);
        if (unc || mh || tk) begin
            m_v[ix] = 1'b1; m_tag[ix] = pc[31:4]; m_unc[ix] = unc;
            m_tk[ix] = unc ? 1'b1 : tk;
            m_addr[ix] = unc ? tgt + 4 : tgt;
            m_insn[ix] = unc ? ins : 32'h0;
        end
        @(posedge clk);
        #1;
        chk("R9", "redirect pulse end", {31'b0, redirect}, 32'h0);
    endtask

    task automatic sweep();
        for (int s = 0; s < 48; s++) begin
            logic [31:0] r;
            logic [31:0] pc;
            r  = (s * 37 + 11) ^ (s << 5);
            pc = 32'h0000_1000 | ({30'b0, r[3:2]} % 3) << 4 | {r[1:0], 2'b00};
            step(pc, r[4] & ~r[6], r[5] | r[0], 32'h8000 + {r[8:5], 4'h0},
                 32'hC0DE_0000 | s, "R8");
        end
    endtask

    initial begin
        #800000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_v[i] = 0; m_tag[i] = '0; m_unc[i] = 0; m_tk[i] = 0; m_addr[i] = '0; m_insn[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int i = 0; i < 4; i++) look(32'h0000_0100 + i * 4, "R1");
        chk("R1", "lk_next_pc literal", lk_next_pc, 32'h0000_0110);
        chk("R1", "redirect", {31'b0, redirect}, 32'h0);
        chk("R1", "cnt_miss", {28'b0, cnt_miss}, 32'h0);
        // R3: not-taken miss leaves no entry
        step(32'h0000_1000, 0, 0, 32'h2000, 0, "R3");
        look(32'h0000_1000, "R3");
        chk("R3", "no allocation", {31'b0, lk_hit}, 32'h0);
        // R2: taken miss allocates and redirects
        step(32'h0000_1000, 0, 1, 32'h2000, 0, "R2");
        look(32'h0000_1000, "R2");
        chk("R2", "next literal", lk_next_pc, 32'h0000_2000);
        step(32'h0000_1000, 0, 1, 32'h2000, 0, "R2");
        // R6: wrong direction on a hit
        step(32'h0000_1000, 0, 0, 32'h2000, 0, "R6");
        look(32'h0000_1000, "R6");
        chk("R6", "next after flip", lk_next_pc, 32'h0000_1004);
        // R4: unconditional allocation and fold
        step(32'h0000_1008, 1, 0, 32'h3000, 32'hA5A5_0001, "R4");
        look(32'h0000_1008, "R4");
        chk("R4", "insn literal", lk_insn, 32'hA5A5_0001);
        chk("R4", "next literal", lk_next_pc, 32'h0000_3004);
        // R5: folded resolution
        step(32'h0000_1008, 1, 0, 32'h3000, 32'hA5A5_0001, "R5");
        chk("R5", "cnt_fold literal", {28'b0, cnt_fold}, 32'h1);
        // R7: low bits ignored, aliasing replaces
        look(32'h0000_100B, "R7");
        chk("R7", "low bits ignored", {31'b0, lk_fold}, 32'h1);
        look(32'h0000_1018, "R7");
        step(32'h0000_1018, 1, 0, 32'h4000, 32'h5A5A_0002, "R7");
        look(32'h0000_1008, "R7");
        chk("R7", "old tag evicted", {31'b0, lk_hit}, 32'h0);
        // R8: sweep across indices and tags, counters saturate
        sweep();
        chk("R8", "cnt_miss saturated", {28'b0, cnt_miss}, CMAX);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule